// File: doc/BRIEF.md
# USB Bulk-In Frame Segmenter

This block moves received Ethernet frames, already held in a byte-wide buffer, out through a USB bulk-in endpoint. The head of a frame-descriptor queue gives the frame's buffer address, its byte length and a receive-status byte. The block cuts the frame into packets of the endpoint's maximum size. It adds the status byte after the last frame byte and streams each packet toward the USB device controller one byte per cycle.

The device controller raises a request for every IN token. If no frame is queued, the block answers with a NAK pulse. Otherwise it sends the packet at the current segment offset and waits for the host's answer. An ACK moves the offset on to the next packet. A NAK or a timeout leaves the offset unchanged, so the next request sends the same bytes again. A frame ends with a short packet, or with a zero-length packet when the frame plus its status byte fills the last packet exactly. The descriptor is handed back only once that final packet has been ACKed.

Top module: `bulkin_segmenter`

## Requirements
- R1: The packet size is 64 bytes when `highSpeed` is 0 and 512 bytes when it is 1. The size is taken from `highSpeed` when the frame's first packet is requested. Changing `highSpeed` later in the same frame does not change the packet size of that frame.
- R2: One frame is sent as `descLen` buffer bytes, read from addresses `descAddr`, `descAddr`+1 and so on in order, followed by `descStatus` as the last byte. The transfer is therefore `descLen`+1 bytes long.
- R3: While idle with a frame queued, `pktReady` is 1 and `pktLen` shows the size of the next packet: the smaller of the bytes still to send and the packet size. A packet shorter than the packet size is the last one of the frame.
- R4: When the bytes still to send equal zero, `pktLen` is 0. A request then produces a one-cycle `txZlp` pulse and no data bytes, and that zero-length packet is the last one of the frame.
- R5: A request while `descValid` is 0 produces a one-cycle `inNak` pulse in the cycle after the request, and no data and no `txZlp`.
- R6: For a non-empty packet, `txValid` is high for exactly `pktLen` consecutive cycles, starting two cycles after the request cycle. `txLast` marks the final byte.
- R7: An ACK after a packet moves the segment offset forward by that packet's length. The next request then sends the bytes that follow.
- R8: A NAK or a timeout after a packet leaves the offset unchanged. The next request sends the same packet again, byte for byte.
- R9: `descRelease` is a one-cycle pulse in the cycle after the ACK of a frame's final packet, whether that packet is short or zero-length. It is never raised after any other handshake.
- R10: After reset, `txValid`, `txLast`, `txZlp`, `inNak` and `descRelease` are 0, and the first request of a queued frame starts at offset 0.
- R11: A handshake input that arrives while no packet is waiting for an answer is ignored. It moves no offset and releases no descriptor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| highSpeed | input | 1 | 1 selects 512-byte packets, 0 selects 64-byte packets |
| descValid | input | 1 | A frame descriptor is at the queue head |
| descAddr | input | ADDR_W | Buffer address of the frame's first byte |
| descLen | input | LEN_W | Frame length in bytes, without the status byte |
| descStatus | input | 8 | Receive-status byte sent after the frame |
| descRelease | output | 1 | Pulse: the head descriptor has been fully sent and ACKed |
| bufRdEn | output | 1 | Buffer read strobe |
| bufRdAddr | output | ADDR_W | Buffer read address |
| bufRdData | input | 8 | Buffer read data, valid one cycle after the strobe |
| txReq | input | 1 | Pulse: the controller asks for a data stage (IN token) |
| pktReady | output | 1 | A packet is available for the next request |
| pktLen | output | PLEN_W | Length of the next packet |
| txValid | output | 1 | A data byte is on `txData` |
| txData | output | 8 | Packet data byte |
| txLast | output | 1 | Marks the last byte of a packet |
| txZlp | output | 1 | Pulse: a zero-length packet is being sent |
| inNak | output | 1 | Pulse: the request is answered with NAK |
| hsAck | input | 1 | The host ACKed the packet |
| hsNak | input | 1 | The host NAKed the packet |
| hsTimeout | input | 1 | The host did not answer the packet |

## Verification
The assertions rely on a few rules for the inputs. The head descriptor holds steady from its first request until `descRelease`. Requests and handshakes are single-cycle pulses. At most one of the three handshake inputs is high in any cycle. A request never arrives while a packet is still streaming or waiting for its answer. The bench follows these rules by driving everything from tasks that wait for the end of each packet before they answer. It drops `descValid` in the cycle the release is seen. It sends handshakes outside the waiting window only in the directed test written for R11.

// File: rtl/seg_pkg.sv
package seg_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SEND,
    ST_WAIT
  } segState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic startPkt;  // latch the next packet's length, clear byte counter
    logic issue;     // read one byte this cycle
    logic advance;   // ACK: move offset past the current packet
    logic endFrame;  // ACK of final packet: offset back to zero
  } segStrobe_t;

endpackage

// File: rtl/seg_datapath.sv
module seg_datapath
  import seg_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int LEN_W  = 11,
  parameter int FS_PKT = 64,
  parameter int HS_PKT = 512,
  parameter int PLEN_W = $clog2(HS_PKT + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  segStrobe_t        strb,
  input  logic              highSpeed,
  input  logic [ADDR_W-1:0] descAddr,
  input  logic [LEN_W-1:0]  descLen,
  input  logic [7:0]        descStatus,
  input  logic [7:0]        bufRdData,
  output logic [PLEN_W-1:0] pktLen,
  output logic              pktFinal,
  output logic              issueLast,
  output logic              bufRdEn,
  output logic [ADDR_W-1:0] bufRdAddr,
  output logic              txValid,
  output logic [7:0]        txData,
  output logic              txLast
);

  localparam int TOT_W = LEN_W + 1;

  logic [TOT_W-1:0]  pktStartQ;
  logic              modeHsQ;
  logic [PLEN_W-1:0] cntQ;
  logic [PLEN_W-1:0] curLenQ;
  logic              validQ;
  logic              statusSelQ;
  logic              lastQ;

  logic [TOT_W-1:0]  frameTotal;
  logic [TOT_W-1:0]  remain;
  logic [TOT_W-1:0]  maxPkt;
  logic [TOT_W-1:0]  byteOff;
  logic              effHs;
  logic              isStatus;

  // Packet size: live mode at frame start, latched mode afterwards
  always_comb begin
    frameTotal = TOT_W'(descLen) + TOT_W'(1);
    effHs      = (pktStartQ == '0) ? highSpeed : modeHsQ;
    maxPkt     = effHs ? TOT_W'(HS_PKT) : TOT_W'(FS_PKT);
    remain     = frameTotal - pktStartQ;
    pktFinal   = remain < maxPkt;
    pktLen     = pktFinal ? PLEN_W'(remain) : PLEN_W'(maxPkt);
  end

  // Byte addressing within the frame
  always_comb begin
    byteOff   = pktStartQ + TOT_W'(cntQ);
    isStatus  = byteOff == TOT_W'(descLen);
    bufRdEn   = strb.issue && !isStatus;
    bufRdAddr = descAddr + ADDR_W'(byteOff);
    issueLast = cntQ == (curLenQ - PLEN_W'(1));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pktStartQ  <= '0;
      modeHsQ    <= 1'b0;
      cntQ       <= '0;
      curLenQ    <= '0;
      validQ     <= 1'b0;
      statusSelQ <= 1'b0;
      lastQ      <= 1'b0;
    end else begin
      if (strb.startPkt) begin
        cntQ    <= '0;
        curLenQ <= pktLen;
        if (pktStartQ == '0) modeHsQ <= highSpeed;
      end else if (strb.issue) begin
        cntQ <= cntQ + PLEN_W'(1);
      end
      if (strb.endFrame)     pktStartQ <= '0;
      else if (strb.advance) pktStartQ <= pktStartQ + TOT_W'(curLenQ);
      validQ     <= strb.issue;
      statusSelQ <= isStatus;
      lastQ      <= strb.issue && issueLast;
    end
  end

  assign txValid = validQ;
  assign txData  = statusSelQ ? descStatus : bufRdData;
  assign txLast  = lastQ;

  // R6
  issue_in_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.issue |-> (cntQ < curLenQ));

  // R7
  offset_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    descValid_unused_guard() |-> (pktStartQ <= frameTotal));

  function automatic logic descValid_unused_guard();
    return 1'b1;
  endfunction

  // R6
  last_has_data_chk: assert property (@(posedge clk) disable iff (!rstN)
    txLast |-> txValid);

endmodule

// File: rtl/seg_control.sv
module seg_control
  import seg_pkg::*;
#(
  parameter int PLEN_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              txReq,
  input  logic              descValid,
  input  logic              hsAck,
  input  logic              hsNak,
  input  logic              hsTimeout,
  input  logic [PLEN_W-1:0] pktLen,
  input  logic              pktFinal,
  input  logic              issueLast,
  output segStrobe_t        strb,
  output logic              pktReady,
  output logic              inNak,
  output logic              txZlp,
  output logic              descRelease
);

  segState_t stateQ, stateD;
  logic      finalQ;
  logic      nakD, zlpD, relD;

  always_comb begin
    stateD = stateQ;
    strb   = '0;
    nakD   = 1'b0;
    zlpD   = 1'b0;
    relD   = 1'b0;
    unique case (stateQ)
      ST_IDLE: begin
        if (txReq) begin
          if (!descValid) begin
            nakD = 1'b1;
          end else begin
            strb.startPkt = 1'b1;
            if (pktLen == '0) begin
              zlpD   = 1'b1;
              stateD = ST_WAIT;
            end else begin
              stateD = ST_SEND;
            end
          end
        end
      end
      ST_SEND: begin
        strb.issue = 1'b1;
        if (issueLast) stateD = ST_WAIT;
      end
      ST_WAIT: begin
        if (hsAck) begin
          strb.advance  = 1'b1;
          strb.endFrame = finalQ;
          relD          = finalQ;
          stateD        = ST_IDLE;
        end else if (hsNak || hsTimeout) begin
          stateD = ST_IDLE;
        end
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ      <= ST_IDLE;
      finalQ      <= 1'b0;
      inNak       <= 1'b0;
      txZlp       <= 1'b0;
      descRelease <= 1'b0;
    end else begin
      stateQ      <= stateD;
      if (strb.startPkt) finalQ <= pktFinal;
      inNak       <= nakD;
      txZlp       <= zlpD;
      descRelease <= relD;
    end
  end

  assign pktReady = (stateQ == ST_IDLE) && descValid;

  // R9
  release_after_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    descRelease |-> $past(hsAck));

  // R5
  nak_no_desc_chk: assert property (@(posedge clk) disable iff (!rstN)
    inNak |-> $past(txReq && !descValid));

  // R4
  zlp_is_final_chk: assert property (@(posedge clk) disable iff (!rstN)
    txZlp |-> finalQ);

  // R8
  replay_no_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_WAIT && !hsAck && (hsNak || hsTimeout)) |=> (!descRelease && stateQ == ST_IDLE));

  // R11
  idle_hs_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_IDLE && hsAck) |=> !descRelease);

endmodule

// File: rtl/bulkin_segmenter.sv
module bulkin_segmenter
  import seg_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int LEN_W  = 11,
  parameter int FS_PKT = 64,
  parameter int HS_PKT = 512,
  parameter int PLEN_W = $clog2(HS_PKT + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              highSpeed,
  input  logic              descValid,
  input  logic [ADDR_W-1:0] descAddr,
  input  logic [LEN_W-1:0]  descLen,
  input  logic [7:0]        descStatus,
  output logic              descRelease,
  output logic              bufRdEn,
  output logic [ADDR_W-1:0] bufRdAddr,
  input  logic [7:0]        bufRdData,
  input  logic              txReq,
  output logic              pktReady,
  output logic [PLEN_W-1:0] pktLen,
  output logic              txValid,
  output logic [7:0]        txData,
  output logic              txLast,
  output logic              txZlp,
  output logic              inNak,
  input  logic              hsAck,
  input  logic              hsNak,
  input  logic              hsTimeout
);

  segStrobe_t strb;
  logic       pktFinal;
  logic       issueLast;

  seg_control #(.PLEN_W(PLEN_W)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .txReq      (txReq),
    .descValid  (descValid),
    .hsAck      (hsAck),
    .hsNak      (hsNak),
    .hsTimeout  (hsTimeout),
    .pktLen     (pktLen),
    .pktFinal   (pktFinal),
    .issueLast  (issueLast),
    .strb       (strb),
    .pktReady   (pktReady),
    .inNak      (inNak),
    .txZlp      (txZlp),
    .descRelease(descRelease)
  );

  seg_datapath #(
    .ADDR_W(ADDR_W),
    .LEN_W (LEN_W),
    .FS_PKT(FS_PKT),
    .HS_PKT(HS_PKT),
    .PLEN_W(PLEN_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .highSpeed (highSpeed),
    .descAddr  (descAddr),
    .descLen   (descLen),
    .descStatus(descStatus),
    .bufRdData (bufRdData),
    .pktLen    (pktLen),
    .pktFinal  (pktFinal),
    .issueLast (issueLast),
    .bufRdEn   (bufRdEn),
    .bufRdAddr (bufRdAddr),
    .txValid   (txValid),
    .txData    (txData),
    .txLast    (txLast)
  );

  // R1
  pkt_size_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    pktReady |-> (int'(pktLen) <= HS_PKT));

endmodule

// File: tb/sim_bulkin_segmenter.sv
module sim_bulkin_segmenter;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 12;
  localparam int LEN_W  = 11;
  localparam int PLEN_W = 10;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              highSpeed = 1'b0;
  logic              descValid = 1'b0;
  logic [ADDR_W-1:0] descAddr = '0;
  logic [LEN_W-1:0]  descLen = '0;
  logic [7:0]        descStatus = '0;
  logic              descRelease;
  logic              bufRdEn;
  logic [ADDR_W-1:0] bufRdAddr;
  logic [7:0]        bufRdData = '0;
  logic              txReq = 1'b0;
  logic              pktReady;
  logic [PLEN_W-1:0] pktLen;
  logic              txValid;
  logic [7:0]        txData;
  logic              txLast;
  logic              txZlp;
  logic              inNak;
  logic              hsAck = 1'b0;
  logic              hsNak = 1'b0;
  logic              hsTimeout = 1'b0;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  bulkin_segmenter u0 (.*);

  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic logic [7:0] memByte(input logic [ADDR_W-1:0] a);
    return a[7:0] * 8'd13 + {4'h0, a[11:8]};
  endfunction

  always @(posedge clk) if (bufRdEn) bufRdData <= memByte(bufRdAddr);

  // {len[10:0], status[7:0], hs, mode[1:0]}; mode 0 plain, 1 NAK first try,
  // 2 timeout first try, 3 flip highSpeed after the first ACK
  localparam logic [21:0] VECS [0:8] = '{
    {11'd10,  8'hA5, 1'b0, 2'd0},
    {11'd63,  8'h3C, 1'b0, 2'd0},
    {11'd127, 8'h0F, 1'b0, 2'd1},
    {11'd100, 8'h81, 1'b0, 2'd2},
    {11'd511, 8'h7E, 1'b1, 2'd0},
    {11'd600, 8'hC3, 1'b1, 2'd1},
    {11'd0,   8'h55, 1'b0, 2'd0},
    {11'd150, 8'h99, 1'b0, 2'd3},
    {11'd700, 8'h12, 1'b1, 2'd3}
  };

  task automatic check(input logic ok, input string req, input string what,
                       input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // One IN request; returns at the negedge where the outcome is known
  task automatic runIn(input int off, input int len, input logic [7:0] st,
                       input logic [ADDR_W-1:0] base, output int nBytes,
                       output int nBad, output logic sawZlp, output logic sawNak,
                       output int firstGap);
    bit done = 0;
    nBytes = 0; nBad = 0; sawZlp = 0; sawNak = 0; firstGap = -1;
    txReq = 1'b1;
    @(negedge clk);
    txReq = 1'b0;
    for (int c = 0; c < 700 && !done; c++) begin
      if (inNak) begin sawNak = 1; done = 1; end
      else if (txZlp) begin sawZlp = 1; done = 1; end
      else if (txValid) begin
        automatic int idx = off + nBytes;
        automatic logic [7:0] exp = (idx < len) ? memByte(base + ADDR_W'(idx)) : st;
        if (firstGap < 0) firstGap = c;
        if (txData !== exp) nBad++;
        nBytes++;
        if (txLast) done = 1;
      end
      if (!done) @(negedge clk);
    end
  endtask

  task automatic sendFrame(input int vi, input logic [21:0] v);
    automatic int len = int'(v[21:11]);
    automatic logic [7:0] st = v[10:3];
    automatic logic hs = v[2];
    automatic int mode = int'(v[1:0]);
    automatic logic [ADDR_W-1:0] base = ADDR_W'(12'h100 + vi * 40);
    automatic int total = len + 1;
    automatic int maxp = hs ? 512 : 64;
    automatic int off = 0;
    automatic bit done = 0;
    automatic bit firstAck = 1;
    int nb, bad, gap;
    logic zl, nk;
    descAddr = base; descLen = LEN_W'(len); descStatus = st;
    descValid = 1'b1; highSpeed = hs;
    @(negedge clk);
    while (!done) begin
      automatic int rem = total - off;
      automatic int expLen = (rem < maxp) ? rem : maxp;
      automatic bit fin = rem < maxp;
      // R1 R3
      check(pktReady && int'(pktLen) == expLen, "R3", $sformatf("vec%0d pktLen", vi),
            int'(pktLen), expLen);
      if (mode == 1 || mode == 2) begin
        runIn(off, len, st, base, nb, bad, zl, nk, gap);
        if (mode == 1) hsNak = 1'b1; else hsTimeout = 1'b1;
        @(negedge clk);
        hsNak = 1'b0; hsTimeout = 1'b0;
        // R8
        check(!descRelease, "R8", "release after retry", int'(descRelease), 0);
        @(negedge clk);
      end
      runIn(off, len, st, base, nb, bad, zl, nk, gap);
      // R2 R7 R8: bytes match buffer then status at this offset
      check(bad == 0, "R2", $sformatf("vec%0d off%0d data errors", vi, off), bad, 0);
      // R6
      check(nb == expLen, "R6", $sformatf("vec%0d off%0d byte count", vi, off), nb, expLen);
      if (expLen > 0)
        check(gap == 1, "R6", "first byte latency", gap, 1);
      // R4
      check(zl == (expLen == 0), "R4", "zero-length marker", int'(zl), int'(expLen == 0));
      hsAck = 1'b1;
      @(negedge clk);
      hsAck = 1'b0;
      // R9
      check(descRelease == fin, "R9", $sformatf("vec%0d release", vi),
            int'(descRelease), int'(fin));
      if (fin) begin descValid = 1'b0; done = 1; end
      off += expLen;
      if (firstAck && mode == 3) highSpeed = ~highSpeed;
      firstAck = 0;
      @(negedge clk);
      check(!descRelease, "R9", "release one cycle", int'(descRelease), 0);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    int nb, bad, gap;
    logic zl, nk;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R10 reset state
    check(!txValid && !txLast && !txZlp && !inNak && !descRelease && !pktReady,
          "R10", "outputs after reset", int'(txValid | txZlp | inNak | descRelease), 0);

    // R5: request with nothing queued
    runIn(0, 0, 8'h00, '0, nb, bad, zl, nk, gap);
    check(nk && nb == 0 && !zl, "R5", "nak with no frame", int'(nk), 1);
    @(negedge clk);
    check(!inNak, "R5", "nak single pulse", int'(inNak), 0);

    // Table of frames
    foreach (VECS[i]) sendFrame(i, VECS[i]);

    // R11: handshakes while idle are ignored
    descAddr = 12'h800; descLen = 11'd70; descStatus = 8'hEE;
    descValid = 1'b1; highSpeed = 1'b0;
    hsAck = 1'b1; @(negedge clk); hsAck = 1'b0;
    hsTimeout = 1'b1; @(negedge clk); hsTimeout = 1'b0;
    check(!descRelease, "R11", "no release from idle ack", int'(descRelease), 0);
    check(int'(pktLen) == 64, "R11", "offset unchanged by idle ack", int'(pktLen), 64);
    runIn(0, 70, 8'hEE, 12'h800, nb, bad, zl, nk, gap);
    check(bad == 0 && nb == 64, "R11", "first packet from offset 0", nb, 64);
    hsAck = 1'b1; @(negedge clk); hsAck = 1'b0;
    check(!descRelease, "R9", "no release on non-final ack", int'(descRelease), 0);
    @(negedge clk);
    check(int'(pktLen) == 7, "R7", "second packet length", int'(pktLen), 7);
    runIn(64, 70, 8'hEE, 12'h800, nb, bad, zl, nk, gap);
    check(bad == 0 && nb == 7, "R7", "second packet data", nb, 7);

    // R10: reset mid-frame restarts at offset 0
    rstN = 1'b0; @(negedge clk); rstN = 1'b1; @(negedge clk);
    check(int'(pktLen) == 64 && !txValid, "R10", "offset zero after reset", int'(pktLen), 64);
    descValid = 1'b0;
    @(negedge clk);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule